// File: doc/BRIEF.md
# Multi-Channel Frame Descriptor Fetcher

This block is the descriptor front end of a seven-channel display DMA engine. A pulse on `frame_start` begins a pass. The block visits the channels in ascending order. For each enabled channel it picks the address of the next descriptor, reads the four-word descriptor through a simple memory read port, and loads the channel's descriptor registers. The next descriptor address is either a pending branch target or the chained next pointer. The pixel transfer that follows is the job of other logic. That logic reads the loaded registers and watches two event vectors: `branch_evt` for consumed branches and `buserr_evt` for bad addresses.

Software programs two things through a register write port: a next-descriptor pointer per channel and a branch register per channel. A branch register overrides chaining for exactly one frame. The channel enables come from the main display enable, the overlay enables, the dual-panel select and the cursor enable. Every register can be read back through a combinational read port.

Top module: `frame_desc_fetcher`

## Requirements
- R1: Each channel has its own enable. Channel 0 follows `main_en`. Channel 1 follows `ovl1_en` OR `dual_panel_sel`. Channels 2, 3 and 4 follow `ovl2_en`. Channel 5 follows `cursor_en`. Channel 6 is never enabled. A disabled channel is not fetched, and its source register reads 0 after the pass.
- R2: An enabled channel fetches from one of two addresses. If the request bit (bit 0) of its branch register is set, the address is the branch register with bits 3:0 cleared. Otherwise it is the stored next pointer. The four words are, in order: next pointer, source, frame ID and command. They appear at 0x200+16*ch with offsets +0, +4, +8 and +0xC. The stored next pointer has bits 3:0 cleared, and the command word is stored unchanged.
- R3: A fetch that uses the branch clears the request bit. It pulses `branch_evt[ch]` for one cycle only if bit 1 of the branch register is set. The following frame chains from the fetched next pointer.
- R4: Branch registers sit at 0x20+4*ch for channels 0 to 4, and at 0x110 and 0x114 for channels 5 and 6. Writes to them are masked with 0xFFFFFFF3. Writes to a next pointer are masked with 0xFFFFFFF0.
- R5: A descriptor address is in the window when it is at least MEM_BASE and its last byte fits below MEM_BASE+MEM_BYTES. A descriptor address outside the window issues no memory request. It clears the channel's source register and pulses `buserr_evt[ch]`. The other descriptor registers keep their values.
- R6: After a fetch, a source word is flagged if it is zero or lies outside [MEM_BASE, MEM_BASE+MEM_BYTES], bounds inclusive. A flagged source pulses `buserr_evt[ch]` and is still stored.
- R7: Channels are fetched in ascending order, with one memory request pulse per descriptor. Only one request is outstanding at a time. A channel's registers change only after its fourth word arrives, however long the memory stalls.
- R8: `busy` rises the cycle after an accepted `frame_start` and falls after the last channel has been handled. With no channel enabled, `busy` is high for 7 cycles. A `frame_start` that arrives while `busy` is high is ignored.
- R9: A software write to a branch register may land in the same cycle that the pass consumes that register. The fetch then uses the old contents, and the written value is kept, including its request bit.
- R10: After reset every register reads 0, `busy` and `mem_req` are low, and no event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that starts a pass |
| main_en | input | 1 | Main display enable (channel 0) |
| ovl1_en | input | 1 | Overlay 1 enable (channel 1) |
| dual_panel_sel | input | 1 | Dual-panel select (channel 1) |
| ovl2_en | input | 1 | Overlay 2 enable (channels 2 to 4) |
| cursor_en | input | 1 | Cursor enable (channel 5) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | REG_AW | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | REG_AW | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| busy | output | 1 | Pass in progress |
| branch_evt | output | NUM_CH | Branch-taken interrupt pulses, one bit per channel |
| buserr_evt | output | NUM_CH | Bus-error pulses, one bit per channel |

## Verification
Two functions can fall in the same clock edge: a software write to a branch register, and the pass consuming that register to clear its request bit. The bench starts a pass and drives a channel-0 branch write in the following cycle. That write lands on the edge where channel 0 is selected. The check is twofold. The descriptor loaded must come from the old branch target. The branch register must read back the newly written value with its request bit still set, and that value must steer the next frame.

// File: rtl/ffd_pkg.sv
package ffd_pkg;

   localparam int unsigned WORD_W      = 32;
   localparam int unsigned DESC_WORDS  = 4;
   localparam int unsigned DESC_BYTES  = DESC_WORDS * (WORD_W / 8);

   // register map
   localparam int unsigned BR_LO_BASE  = 32'h020;
   localparam int unsigned BR_LO_COUNT = 5;
   localparam int unsigned BR_HI_BASE  = 32'h110;
   localparam int unsigned DESC_BASE   = 32'h200;
   localparam int unsigned DESC_STRIDE = 16;

   // channel groups for enable derivation
   localparam int unsigned CH_MAIN     = 0;
   localparam int unsigned CH_OVL1     = 1;
   localparam int unsigned CH_OVL2_LO  = 2;
   localparam int unsigned CH_OVL2_HI  = 4;
   localparam int unsigned CH_CURSOR   = 5;

   // branch register fields
   localparam int unsigned BR_REQ_BIT  = 0;
   localparam int unsigned BR_INT_BIT  = 1;

   typedef logic [WORD_W-1:0] word_t;

   localparam word_t BRANCH_MASK = 32'hFFFF_FFF3;
   localparam word_t PTR_MASK    = 32'hFFFF_FFF0;

   typedef struct packed {
      word_t nxt;
      word_t src;
      word_t fid;
      word_t cmd;
   } desc_t;

   function automatic int unsigned branch_offset(input int unsigned ch);
      return (ch < BR_LO_COUNT) ? BR_LO_BASE + 4 * ch
                                : BR_HI_BASE + 4 * (ch - BR_LO_COUNT);
   endfunction

   function automatic int unsigned desc_offset(input int unsigned ch, input int unsigned word);
      return DESC_BASE + DESC_STRIDE * ch + 4 * word;
   endfunction

   function automatic logic desc_in_window(input word_t a, input word_t base, input word_t bytes);
      logic [WORD_W:0] lim;
      logic [WORD_W:0] hi;
      lim = {1'b0, base} + {1'b0, bytes};
      hi  = {1'b0, a} + (WORD_W+1)'(DESC_BYTES);
      return (a >= base) && (hi <= lim);
   endfunction

   function automatic logic src_in_window(input word_t a, input word_t base, input word_t bytes);
      logic [WORD_W:0] lim;
      lim = {1'b0, base} + {1'b0, bytes};
      return (a != '0) && (a >= base) && ({1'b0, a} <= lim);
   endfunction

endpackage

// File: rtl/ffd_enable_map.sv
module ffd_enable_map
   import ffd_pkg::*;
#(
   parameter int unsigned NUM_CH = 7
) (
   input  logic              main_en,
   input  logic              ovl1_en,
   input  logic              dual_panel_sel,
   input  logic              ovl2_en,
   input  logic              cursor_en,
   output logic [NUM_CH-1:0] chan_en
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_map
      if (c == CH_MAIN) begin : g_main
         assign chan_en[c] = main_en;
      end else if (c == CH_OVL1) begin : g_ovl1
         assign chan_en[c] = ovl1_en | dual_panel_sel;
      end else if (c >= CH_OVL2_LO && c <= CH_OVL2_HI) begin : g_ovl2
         assign chan_en[c] = ovl2_en;
      end else if (c == CH_CURSOR) begin : g_cursor
         assign chan_en[c] = cursor_en;
      end else begin : g_off
         assign chan_en[c] = 1'b0;
      end
   end

endmodule

// File: rtl/ffd_chan_regs.sv
module ffd_chan_regs
   import ffd_pkg::*;
#(
   parameter int unsigned NUM_CH = 7,
   parameter int unsigned REG_AW = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  word_t             wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output word_t             rd_data,
   input  logic [NUM_CH-1:0] br_clr,
   input  logic [NUM_CH-1:0] commit,
   input  desc_t             commit_desc,
   input  logic [NUM_CH-1:0] src_clr,
   output word_t             br_q  [NUM_CH],
   output word_t             nxt_q [NUM_CH]
);

   word_t src_a [NUM_CH];
   word_t fid_a [NUM_CH];
   word_t cmd_a [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned BR_OFF  = branch_offset(c);
      localparam int unsigned NXT_OFF = desc_offset(c, 0);

      word_t br_r, nxt_r, src_r, fid_r, cmd_r;
      logic  hit_br, hit_nxt;

      assign hit_br  = wr_en && (wr_addr == REG_AW'(BR_OFF));
      assign hit_nxt = wr_en && (wr_addr == REG_AW'(NXT_OFF));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            br_r  <= '0;
            nxt_r <= '0;
            src_r <= '0;
            fid_r <= '0;
            cmd_r <= '0;
         end else begin
            // software write outranks the hardware consume of the request bit
            if (hit_br)
               br_r <= wr_data & BRANCH_MASK;
            else if (br_clr[c])
               br_r[BR_REQ_BIT] <= 1'b0;

            if (commit[c]) begin
               nxt_r <= commit_desc.nxt & PTR_MASK;
               src_r <= commit_desc.src;
               fid_r <= commit_desc.fid;
               cmd_r <= commit_desc.cmd;
            end else begin
               if (hit_nxt)
                  nxt_r <= wr_data & PTR_MASK;
               if (src_clr[c])
                  src_r <= '0;
            end
         end
      end

      assign br_q[c]  = br_r;
      assign nxt_q[c] = nxt_r;
      assign src_a[c] = src_r;
      assign fid_a[c] = fid_r;
      assign cmd_a[c] = cmd_r;
   end

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_addr == REG_AW'(branch_offset(c))) rd_data = br_q[c];
         if (rd_addr == REG_AW'(desc_offset(c, 0))) rd_data = nxt_q[c];
         if (rd_addr == REG_AW'(desc_offset(c, 1))) rd_data = src_a[c];
         if (rd_addr == REG_AW'(desc_offset(c, 2))) rd_data = fid_a[c];
         if (rd_addr == REG_AW'(desc_offset(c, 3))) rd_data = cmd_a[c];
      end
   end

endmodule

// File: rtl/ffd_sequencer.sv
module ffd_sequencer
   import ffd_pkg::*;
#(
   parameter int unsigned NUM_CH    = 7,
   parameter word_t       MEM_BASE  = 32'hA000_0000,
   parameter word_t       MEM_BYTES = 32'h0400_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [NUM_CH-1:0] chan_en,
   input  word_t             br_q  [NUM_CH],
   input  word_t             nxt_q [NUM_CH],
   output logic              mem_req,
   output word_t             mem_addr,
   input  logic              mem_rvalid,
   input  word_t             mem_rdata,
   output logic              busy,
   output logic [NUM_CH-1:0] br_clr,
   output logic [NUM_CH-1:0] commit,
   output desc_t             commit_desc,
   output logic [NUM_CH-1:0] src_clr,
   output logic [NUM_CH-1:0] branch_evt,
   output logic [NUM_CH-1:0] buserr_evt
);

   localparam int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int unsigned BEAT_W = $clog2(DESC_WORDS);

   typedef enum logic [1:0] {S_IDLE, S_SEL, S_WAIT} state_t;

   state_t            state;
   logic [CH_W-1:0]   ch;
   logic [BEAT_W-1:0] beat;
   word_t             w_nxt, w_src, w_fid;

   logic              take_br, want_int, sel_ok, last_ch, fetch_done, sel_en;
   word_t             sel_addr;
   logic [NUM_CH-1:0] ch_oh;

   assign ch_oh      = NUM_CH'(1) << ch;
   assign take_br    = br_q[ch][BR_REQ_BIT];
   assign want_int   = br_q[ch][BR_INT_BIT];
   assign sel_addr   = take_br ? (br_q[ch] & PTR_MASK) : nxt_q[ch];
   assign sel_ok     = desc_in_window(sel_addr, MEM_BASE, MEM_BYTES);
   assign last_ch    = (ch == CH_W'(NUM_CH - 1));
   assign sel_en     = (state == S_SEL) && chan_en[ch];
   assign fetch_done = (state == S_WAIT) && mem_rvalid && (beat == BEAT_W'(DESC_WORDS - 1));

   assign busy        = (state != S_IDLE);
   assign br_clr      = (sel_en && take_br) ? ch_oh : '0;
   assign src_clr     = ((state == S_SEL) && !(chan_en[ch] && sel_ok)) ? ch_oh : '0;
   assign commit      = fetch_done ? ch_oh : '0;
   assign commit_desc = '{nxt: w_nxt, src: w_src, fid: w_fid, cmd: mem_rdata};

   // state after a channel is finished
   state_t          adv_state;
   logic [CH_W-1:0] adv_ch;
   assign adv_state = last_ch ? S_IDLE : S_SEL;
   assign adv_ch    = last_ch ? ch : ch + CH_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         ch         <= '0;
         beat       <= '0;
         mem_req    <= 1'b0;
         mem_addr   <= '0;
         w_nxt      <= '0;
         w_src      <= '0;
         w_fid      <= '0;
         branch_evt <= '0;
         buserr_evt <= '0;
      end else begin
         mem_req    <= 1'b0;
         branch_evt <= '0;
         buserr_evt <= '0;
         unique case (state)
            S_IDLE: begin
               if (frame_start) begin
                  state <= S_SEL;
                  ch    <= '0;
               end
            end
            S_SEL: begin
               if (chan_en[ch]) begin
                  if (take_br && want_int)
                     branch_evt <= ch_oh;
                  if (sel_ok) begin
                     mem_req  <= 1'b1;
                     mem_addr <= sel_addr;
                     beat     <= '0;
                     state    <= S_WAIT;
                  end else begin
                     buserr_evt <= ch_oh;
                     state      <= adv_state;
                     ch         <= adv_ch;
                  end
               end else begin
                  state <= adv_state;
                  ch    <= adv_ch;
               end
            end
            S_WAIT: begin
               if (mem_rvalid) begin
                  beat <= beat + BEAT_W'(1);
                  case (beat)
                     BEAT_W'(0): w_nxt <= mem_rdata;
                     BEAT_W'(1): w_src <= mem_rdata;
                     BEAT_W'(2): w_fid <= mem_rdata;
                     default: ;
                  endcase
                  if (fetch_done) begin
                     if (!src_in_window(w_src, MEM_BASE, MEM_BYTES))
                        buserr_evt <= ch_oh;
                     state <= adv_state;
                     ch    <= adv_ch;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher
   import ffd_pkg::*;
#(
   parameter int unsigned NUM_CH    = 7,
   parameter int unsigned REG_AW    = 12,
   parameter word_t       MEM_BASE  = 32'hA000_0000,
   parameter word_t       MEM_BYTES = 32'h0400_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              main_en,
   input  logic              ovl1_en,
   input  logic              dual_panel_sel,
   input  logic              ovl2_en,
   input  logic              cursor_en,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_wr_addr,
   input  logic [31:0]       reg_wr_data,
   input  logic [REG_AW-1:0] reg_rd_addr,
   output logic [31:0]       reg_rd_data,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              busy,
   output logic [NUM_CH-1:0] branch_evt,
   output logic [NUM_CH-1:0] buserr_evt
);

   // elaboration-time parameter checks
   if (NUM_CH != 7) begin : g_bad_ch
      $error("frame_desc_fetcher: register map is laid out for 7 channels");
   end
   if (REG_AW < 12) begin : g_bad_aw
      $error("frame_desc_fetcher: REG_AW too narrow for the register map");
   end
   if (MEM_BASE[3:0] != 4'h0 || MEM_BYTES < DESC_BYTES) begin : g_bad_win
      $error("frame_desc_fetcher: memory window must be aligned and hold a descriptor");
   end

   logic [NUM_CH-1:0] chan_en, br_clr, commit, src_clr;
   desc_t             commit_desc;
   word_t             br_q  [NUM_CH];
   word_t             nxt_q [NUM_CH];

   ffd_enable_map #(.NUM_CH(NUM_CH)) u_map (
      .main_en        (main_en),
      .ovl1_en        (ovl1_en),
      .dual_panel_sel (dual_panel_sel),
      .ovl2_en        (ovl2_en),
      .cursor_en      (cursor_en),
      .chan_en        (chan_en)
   );

   ffd_chan_regs #(.NUM_CH(NUM_CH), .REG_AW(REG_AW)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en),
      .wr_addr     (reg_wr_addr),
      .wr_data     (reg_wr_data),
      .rd_addr     (reg_rd_addr),
      .rd_data     (reg_rd_data),
      .br_clr      (br_clr),
      .commit      (commit),
      .commit_desc (commit_desc),
      .src_clr     (src_clr),
      .br_q        (br_q),
      .nxt_q       (nxt_q)
   );

   ffd_sequencer #(.NUM_CH(NUM_CH), .MEM_BASE(MEM_BASE), .MEM_BYTES(MEM_BYTES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .chan_en     (chan_en),
      .br_q        (br_q),
      .nxt_q       (nxt_q),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .mem_rvalid  (mem_rvalid),
      .mem_rdata   (mem_rdata),
      .busy        (busy),
      .br_clr      (br_clr),
      .commit      (commit),
      .commit_desc (commit_desc),
      .src_clr     (src_clr),
      .branch_evt  (branch_evt),
      .buserr_evt  (buserr_evt)
   );

endmodule

// File: rtl/ffd_checker.sv
module ffd_checker
   import ffd_pkg::*;
#(
   parameter int unsigned NUM_CH    = 7,
   parameter word_t       MEM_BASE  = 32'hA000_0000,
   parameter word_t       MEM_BYTES = 32'h0400_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_req,
   input logic [31:0]       mem_addr,
   input logic [NUM_CH-1:0] branch_evt,
   input logic [NUM_CH-1:0] buserr_evt
);

   assert_req_in_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   assert_req_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (desc_in_window(mem_addr, MEM_BASE, MEM_BYTES) && mem_addr[3:0] == 4'h0));

   assert_single_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_one_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(branch_evt));

   assert_one_buserr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(buserr_evt));

   assert_events_in_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((branch_evt != '0) || (buserr_evt != '0)) |-> $past(busy));

endmodule

bind frame_desc_fetcher ffd_checker #(
   .NUM_CH(NUM_CH), .MEM_BASE(MEM_BASE), .MEM_BYTES(MEM_BYTES)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .branch_evt (branch_evt),
   .buserr_evt (buserr_evt)
);

// File: tb/frame_desc_fetcher_tb_top.sv
`timescale 1ns/1ps
module frame_desc_fetcher_tb_top;

   localparam int unsigned NCH = 7;
   localparam logic [31:0] B   = 32'hA000_0000;
   localparam logic [31:0] E   = 32'hA400_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        main_en = 0, ovl1_en = 0, dual_panel_sel = 0, ovl2_en = 0, cursor_en = 0;
   logic        reg_wr_en = 1'b0;
   logic [11:0] reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [11:0] reg_rd_addr = '0;
   logic [31:0] reg_rd_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;
   logic        busy;
   logic [NCH-1:0] branch_evt, buserr_evt;

   always #4 clk = ~clk;

   frame_desc_fetcher dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .main_en(main_en), .ovl1_en(ovl1_en), .dual_panel_sel(dual_panel_sel),
      .ovl2_en(ovl2_en), .cursor_en(cursor_en),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .busy(busy), .branch_evt(branch_evt), .buserr_evt(buserr_evt)
   );

   // ---------------- memory model and event monitor ----------------
   logic [31:0] bmem [64];
   logic [31:0] fetch_log [64];
   int          fetch_cnt = 0;
   int          brn_cnt [NCH];
   int          err_cnt [NCH];
   logic        gap_en = 1'b0;
   logic        in_gap;
   logic        pend;
   int          beat, gapc;
   logic [5:0]  widx;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rvalid = 1'b0; mem_rdata = '0; pend = 1'b0; beat = 0; gapc = 0; in_gap = 1'b0;
         for (int c = 0; c < NCH; c++) begin brn_cnt[c] = 0; err_cnt[c] = 0; end
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (branch_evt[c]) brn_cnt[c]++;
            if (buserr_evt[c]) err_cnt[c]++;
         end
         mem_rvalid = 1'b0;
         if (mem_req) begin
            fetch_log[fetch_cnt % 64] = mem_addr;
            fetch_cnt++;
            widx = 6'((mem_addr - B) >> 2);
            pend = 1'b1; beat = 0; gapc = 0;
         end
         if (pend) begin
            if (gap_en && beat == 3 && gapc < 4) begin
               gapc++; in_gap = 1'b1;
            end else begin
               in_gap = 1'b0;
               mem_rvalid = 1'b1;
               mem_rdata = bmem[widx + 6'(beat)];
               beat++;
               if (beat == 4) pend = 1'b0;
            end
         end
      end
   end

   // ---------------- bench helpers ----------------
   int n_chk = 0, n_bad = 0;
   int snap_br [NCH];
   int snap_er [NCH];
   int snap_f;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd_addr = a;
      #2 d = reg_rd_data;
   endtask

   task automatic snap();
      for (int c = 0; c < NCH; c++) begin snap_br[c] = brn_cnt[c]; snap_er[c] = err_cnt[c]; end
      snap_f = fetch_cnt;
   endtask

   function automatic logic [31:0] br_mask();
      logic [31:0] m = '0;
      for (int c = 0; c < NCH; c++) m[c] = (brn_cnt[c] != snap_br[c]);
      return m;
   endfunction

   function automatic logic [31:0] er_mask();
      logic [31:0] m = '0;
      for (int c = 0; c < NCH; c++) m[c] = (err_cnt[c] != snap_er[c]);
      return m;
   endfunction

   task automatic frame();
      snap();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      while (busy) @(negedge clk);
   endtask

   task automatic setd(input int i, input logic [31:0] n, s, f, c);
      bmem[i] = n; bmem[i+1] = s; bmem[i+2] = f; bmem[i+3] = c;
   endtask

   // {address, write data, expected readback}
   localparam logic [95:0] VEC [7] = '{
      {32'h020, 32'hFFFF_FFFF, 32'hFFFF_FFF3},
      {32'h030, 32'h1234_567C, 32'h1234_5670},
      {32'h110, 32'h0000_0007, 32'h0000_0003},
      {32'h114, 32'hABCD_EF0F, 32'hABCD_EF03},
      {32'h200, 32'hA000_001F, 32'hA000_0010},
      {32'h260, 32'hFFFF_FFFF, 32'hFFFF_FFF0},
      {32'h210, 32'h1234_5678, 32'h1234_5670}
   };

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [31:0] v;
      int n;
      for (int i = 0; i < 64; i++) bmem[i] = '0;
      setd(0,  B + 32'h10, B + 32'h1000, 32'h11, 32'h0060_0040);
      setd(4,  B,          B + 32'h2000, 32'h22, 32'h0400_0100);
      setd(8,  B + 32'h20, B + 32'h3000, 32'h33, 32'h0020_0010);
      setd(12, B,          B + 32'h4000, 32'h44, 32'h0);
      setd(16, B + 32'h40, 32'h0,        32'h55, 32'h0);
      setd(20, B + 32'h50, E + 32'h10,   32'h66, 32'h0);
      setd(24, B + 32'h60, E,            32'h77, 32'h0);
      setd(28, B + 32'h1F, B + 32'h100,  32'h88, 32'h0);
      setd(60, B,          B + 32'h8000, 32'h99, 32'h0);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      chk("R10 busy", {31'b0, busy}, 32'h0);
      chk("R10 mem_req", {31'b0, mem_req}, 32'h0);
      rd(12'h020, v); chk("R10 branch0", v, 32'h0);
      rd(12'h200, v); chk("R10 next0", v, 32'h0);
      rd(12'h264, v); chk("R10 source6", v, 32'h0);

      // register write masks and placement
      foreach (VEC[i]) begin
         wr(VEC[i][75:64], VEC[i][63:32]);
         rd(VEC[i][75:64], v);
         chk("R4 write mask", v, VEC[i][31:0]);
      end
      foreach (VEC[i]) wr(VEC[i][75:64], 32'h0);

      // basic fetch, ascending order
      main_en = 1; dual_panel_sel = 1;
      wr(12'h200, B); wr(12'h210, B + 32'h20);
      frame();
      chk("R7 fetch count", fetch_cnt - snap_f, 2);
      chk("R7 order first", fetch_log[snap_f % 64], B);
      chk("R7 order second", fetch_log[(snap_f + 1) % 64], B + 32'h20);
      rd(12'h200, v); chk("R2 ch0 next", v, B + 32'h10);
      rd(12'h204, v); chk("R2 ch0 source", v, B + 32'h1000);
      rd(12'h208, v); chk("R2 ch0 id", v, 32'h11);
      rd(12'h20C, v); chk("R2 ch0 cmd", v, 32'h0060_0040);
      rd(12'h218, v); chk("R1 ch1 by dual select", v, 32'h33);
      chk("R6 no error", er_mask(), 32'h0);

      frame();
      rd(12'h208, v); chk("R2 chained ch0 id", v, 32'h22);

      // unaligned next word gets aligned
      dual_panel_sel = 0;
      wr(12'h200, B + 32'h70);
      frame();
      rd(12'h200, v); chk("R2 stored next aligned", v, B + 32'h10);

      // source errors
      dual_panel_sel = 1;
      wr(12'h200, B + 32'h40); wr(12'h210, B + 32'h50);
      frame();
      chk("R6 zero and out-of-window source", er_mask(), 32'h3);
      rd(12'h204, v); chk("R6 zero source stored", v, 32'h0);
      rd(12'h208, v); chk("R6 id still loaded", v, 32'h55);
      dual_panel_sel = 0;
      wr(12'h200, B + 32'h60);
      frame();
      chk("R6 top edge of window accepted", er_mask(), 32'h0);
      rd(12'h204, v); chk("R6 edge source", v, E);

      // descriptor window
      wr(12'h200, E - 32'h10);
      frame();
      chk("R5 last slot fetched", fetch_cnt - snap_f, 1);
      rd(12'h208, v); chk("R5 last slot id", v, 32'h99);
      wr(12'h200, E);
      frame();
      chk("R5 no fetch outside", fetch_cnt - snap_f, 0);
      chk("R5 bus error", er_mask(), 32'h1);
      rd(12'h204, v); chk("R5 source cleared", v, 32'h0);
      rd(12'h208, v); chk("R5 id kept", v, 32'h99);

      // stall between third and fourth word
      gap_en = 1'b1;
      wr(12'h200, B);
      snap();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      do @(posedge clk); while (!in_gap);
      rd(12'h208, v); chk("R7 id unchanged mid fetch", v, 32'h99);
      rd(12'h200, v); chk("R7 next unchanged mid fetch", v, B);
      while (busy) @(negedge clk);
      rd(12'h208, v); chk("R7 id after stall", v, 32'h11);
      gap_en = 1'b0;

      // branch with interrupt
      wr(12'h020, B + 32'h33);
      frame();
      rd(12'h208, v); chk("R2 branch target used", v, 32'h44);
      chk("R3 branch event ch0", br_mask(), 32'h1);
      rd(12'h020, v); chk("R3 request cleared", v, B + 32'h32);
      frame();
      rd(12'h208, v); chk("R3 chained after branch", v, 32'h11);
      chk("R3 no event without request", br_mask(), 32'h0);
      wr(12'h020, B + 32'h11);
      frame();
      rd(12'h208, v); chk("R3 silent branch target", v, 32'h22);
      chk("R3 no event without int bit", br_mask(), 32'h0);

      // collision: write lands on the consume edge
      wr(12'h020, B + 32'h31);
      snap();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      reg_wr_en = 1'b1; reg_wr_addr = 12'h020; reg_wr_data = B + 32'h11;
      @(negedge clk); reg_wr_en = 1'b0;
      while (busy) @(negedge clk);
      rd(12'h208, v); chk("R9 old branch used", v, 32'h44);
      rd(12'h020, v); chk("R9 write kept", v, B + 32'h11);
      frame();
      rd(12'h208, v); chk("R9 written branch used next", v, 32'h22);

      // enable map
      main_en = 0; ovl2_en = 1;
      wr(12'h220, B); wr(12'h230, B + 32'h10); wr(12'h240, B + 32'h20);
      frame();
      chk("R1 overlay2 fetches", fetch_cnt - snap_f, 3);
      chk("R7 overlay2 order", fetch_log[(snap_f + 2) % 64], B + 32'h20);
      rd(12'h204, v); chk("R1 disabled source cleared", v, 32'h0);
      rd(12'h238, v); chk("R1 ch3 id", v, 32'h22);
      ovl2_en = 0; cursor_en = 1;
      wr(12'h250, B + 32'h30);
      frame();
      rd(12'h258, v); chk("R1 cursor ch5 id", v, 32'h44);
      cursor_en = 0; ovl1_en = 1;
      wr(12'h210, B);
      frame();
      rd(12'h218, v); chk("R1 overlay1 ch1 id", v, 32'h11);
      main_en = 1; ovl2_en = 1; cursor_en = 1;
      wr(12'h260, B);
      frame();
      chk("R1 channel6 never fetched", fetch_cnt - snap_f, 6);

      // busy length and ignored start
      main_en = 0; ovl1_en = 0; ovl2_en = 0; cursor_en = 0;
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R8 busy cycles", n, 7);
      main_en = 1;
      wr(12'h200, B);
      snap();
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      @(negedge clk); frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0;
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R8 restart ignored busy", {31'b0, busy}, 32'h0);
      chk("R8 restart ignored fetches", fetch_cnt - snap_f, 1);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule